// File: doc/BRIEF.md
# Serial DAC Write Interface Controller

This block sits between a three-wire serial write link and the control inputs of a voltage-output DAC. A host pulls an active-low frame-select line low, then presents one data bit per serial clock period, and the block captures each bit on the falling serial clock edge. After a fixed number of captured bits it decodes a two-bit operating mode and a data code, and it loads them into the registers that drive the converter's code input and its output-stage mode.

The serial inputs are brought into the system clock domain through two-flop synchronisers, and all edge detection happens on the synchronised values. The system clock must therefore run at least four times faster than the serial clock. A parameter picks one of two frame layouts. The short layout is 16 bits long and carries a 14-bit code. The long layout is 24 bits long, commits on bit 18 with a 16-bit code, and treats its last six bits as don't-care. When the mode goes from any power-down state back to normal, an output-valid flag stays low for a programmable settling interval.

Top module: `serial_dac_ctrl`

## Requirements
- R1: After reset the code output is zero, the mode output is 00 (normal), and the output-valid flag is high.
- R2: In the short layout (`LONG_FRAME`=0), the 16th serial clock falling edge of a frame commits it. The first bit is mode bit 1, the second is mode bit 0, and the next 14 bits are the code, most significant first.
- R3: In the long layout (`LONG_FRAME`=1), the 18th falling edge commits a 16-bit code that follows the two mode bits. Bits 19 to 24 have no effect, and raising select any time after the 18th edge keeps the committed frame.
- R4: If the frame-select line rises before the commit edge, the frame is dropped: neither the code nor the mode changes, and the next frame is decoded from its own bits only.
- R5: After a commit, further serial clock edges have no effect until select has gone high and then low again.
- R6: A committed frame with a nonzero mode (01 = 1 kΩ to ground, 10 = 100 kΩ to ground, 11 = high impedance) updates the mode output but leaves the code output unchanged.
- R7: Output-valid is low whenever the mode is not 00. A commit that moves the mode from a power-down value to 00 holds it low for `EXIT_DELAY_CYCLES` system clocks. A commit from 00 to 00 keeps it high.
- R8: Serial clock edges while select is high are ignored. A frame starts only on a falling edge of select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low synchronous reset (power-on) |
| selN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock; data captured on falling edges |
| sdi | input | 1 | Serial data, most significant bit first |
| dacCode | output | CODE_W (14 or 16) | Code register driving the converter |
| modeOut | output | 2 | Operating mode: 00 normal, 01 1 kΩ, 10 100 kΩ, 11 high-Z |
| outValid | output | 1 | High when the analog output is settled and in normal mode |

## Verification
A serial clock falling edge reaches the synchroniser output two system clocks after it arrives. The edge detector then fires combinationally, and the code and mode registers take the new values on the third system clock edge after the pin changed. The bench holds each serial clock phase for four system clocks, and it samples the outputs no earlier than twelve clocks after the last falling edge of a frame, so every result is already settled when it reads it. The settling flag should rise `EXIT_DELAY_CYCLES` plus three clocks after the commit edge. The bench counts clocks from its last falling edge until the flag rises and accepts only a narrow window around that figure, which catches both an early release and a late one.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } frameState_t;

  typedef struct packed {
    logic clear;
    logic shift;
    logic commit;
  } ctrlStrobe_t;

  localparam logic [1:0] MODE_NORMAL = 2'b00;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic selN,
  input  logic sclk,
  input  logic sdi,
  output logic selLvl,
  output logic selFall,
  output logic sclkFall,
  output logic sdiLvl
);
  localparam int NLINES = 3;
  localparam logic [NLINES-1:0] RST_VAL = 3'b011;

  logic [NLINES-1:0] rawIn;
  logic [NLINES-1:0] syncOut;
  logic [NLINES-1:0] prevOut;

  assign rawIn = {sdi, sclk, selN};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= {STAGES{RST_VAL[g]}};
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevOut <= RST_VAL;
    else       prevOut <= syncOut;
  end

  assign selLvl   = syncOut[0];
  assign selFall  = prevOut[0] & ~syncOut[0];
  assign sclkFall = prevOut[1] & ~syncOut[1];
  assign sdiLvl   = syncOut[2];

endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int COMMIT_BITS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selLvl,
  input  logic        selFall,
  input  logic        sclkFall,
  output ctrlStrobe_t strobes
);
  localparam int CNT_W = $clog2(COMMIT_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(COMMIT_BITS - 1);

  frameState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strobes    = '0;
    unique case (state)
      ST_IDLE: begin
        if (selFall) begin
          strobes.clear = 1'b1;
          bitCntNext    = '0;
          stateNext     = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (selLvl) begin
          strobes.clear = 1'b1;
          bitCntNext    = '0;
          stateNext     = ST_IDLE;
        end else if (sclkFall) begin
          strobes.shift = 1'b1;
          bitCntNext    = bitCnt + 1'b1;
          if (bitCnt == LAST_IDX) begin
            strobes.commit = 1'b1;
            stateNext      = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        if (selLvl) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
#(
  parameter int CODE_W      = 14,
  parameter int EXIT_CYCLES = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic              bitIn,
  output logic [CODE_W-1:0] dacCode,
  output logic [1:0]        modeOut,
  output logic              outValid
);
  localparam int WORD_W = CODE_W + 2;
  localparam int DLY_W  = $clog2(EXIT_CYCLES + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(EXIT_CYCLES);

  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] fullWord;
  logic [1:0]        newMode;
  logic [DLY_W-1:0]  exitCnt;

  assign fullWord = {shiftReg, bitIn};
  assign newMode  = fullWord[WORD_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) shiftReg <= '0;
    else if (strobes.shift)     shiftReg <= fullWord[WORD_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacCode <= '0;
      modeOut <= MODE_NORMAL;
    end else if (strobes.commit) begin
      modeOut <= newMode;
      if (newMode == MODE_NORMAL) dacCode <= fullWord[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exitCnt <= '0;
    end else if (strobes.commit && newMode == MODE_NORMAL && modeOut != MODE_NORMAL) begin
      exitCnt <= DLY_LOAD;
    end else if (strobes.commit && newMode != MODE_NORMAL) begin
      exitCnt <= '0;
    end else if (exitCnt != '0) begin
      exitCnt <= exitCnt - 1'b1;
    end
  end

  assign outValid = (modeOut == MODE_NORMAL) && (exitCnt == '0);

endmodule

// File: rtl/serial_dac_ctrl.sv
module serial_dac_ctrl
  import sdac_pkg::*;
#(
  parameter bit LONG_FRAME        = 1'b0,
  parameter int SYNC_STAGES       = 2,
  parameter int EXIT_DELAY_CYCLES = 2500,
  localparam int CODE_W           = LONG_FRAME ? 16 : 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] dacCode,
  output logic [1:0]        modeOut,
  output logic              outValid
);
  localparam int COMMIT_BITS = CODE_W + 2;

  logic        selLvl, selFall, sclkFall, sdiLvl;
  ctrlStrobe_t strobes;
  logic        commitStb;

  sdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .selLvl(selLvl), .selFall(selFall), .sclkFall(sclkFall), .sdiLvl(sdiLvl)
  );

  sdac_ctrl #(.COMMIT_BITS(COMMIT_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .selLvl(selLvl), .selFall(selFall),
    .sclkFall(sclkFall), .strobes(strobes)
  );

  sdac_datapath #(.CODE_W(CODE_W), .EXIT_CYCLES(EXIT_DELAY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIn(sdiLvl),
    .dacCode(dacCode), .modeOut(modeOut), .outValid(outValid)
  );

  assign commitStb = strobes.commit;

endmodule

// File: rtl/serial_dac_ctrl_checker.sv
module serial_dac_ctrl_checker #(
  parameter int CODE_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic [CODE_W-1:0] dacCode,
  input logic [1:0]        modeOut,
  input logic              outValid,
  input logic              commitStb
);

  p_valid_only_normal_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (modeOut == 2'b00));

  p_rise_after_normal_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> ($past(modeOut) == 2'b00));

  p_code_only_in_normal_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> (modeOut == 2'b00));

  p_single_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> !commitStb);

  p_idle_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selN, 1) && $past(selN, 2) && $past(selN, 3))
      |-> ($stable(dacCode) && $stable(modeOut)));

  p_commit_needs_select_r8: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !($past(selN, 2) && $past(selN, 3)));

endmodule

bind serial_dac_ctrl serial_dac_ctrl_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .dacCode(dacCode),
  .modeOut(modeOut), .outValid(outValid), .commitStb(commitStb)
);

// File: tb/serial_dac_ctrl_bench.sv
module serial_dac_ctrl_bench;
  localparam int EXIT_DLY = 300;
  localparam int HALF     = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selS = 1'b1, selL = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [13:0] codeS;
  logic [15:0] codeL;
  logic [1:0]  modeS, modeL;
  logic        validS, validL;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_dac_ctrl #(.LONG_FRAME(1'b0), .EXIT_DELAY_CYCLES(EXIT_DLY)) u_serial_dac_ctrl (
    .clk(clk), .rstN(rstN), .selN(selS), .sclk(sclk), .sdi(sdi),
    .dacCode(codeS), .modeOut(modeS), .outValid(validS)
  );

  serial_dac_ctrl #(.LONG_FRAME(1'b1), .EXIT_DELAY_CYCLES(EXIT_DLY)) u_serial_dac_ctrl_long (
    .clk(clk), .rstN(rstN), .selN(selL), .sclk(sclk), .sdi(sdi),
    .dacCode(codeL), .modeOut(modeL), .outValid(validL)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Select low, nBits bits MSB first, optional raise of select afterwards.
  task automatic sendBits(input bit toLong, input logic [23:0] w, input int nBits,
                          input bit lower, input bit raise);
    if (lower) begin
      if (toLong) selL = 1'b0; else selS = 1'b0;
      waitc(HALF);
    end
    for (int i = 0; i < nBits; i++) begin
      sdi  = w[nBits-1-i];
      sclk = 1'b1; waitc(HALF);
      sclk = 1'b0; waitc(HALF);
    end
    sclk = 1'b1;
    if (raise) begin
      selS = 1'b1; selL = 1'b1;
      waitc(2 * HALF);
    end
  endtask

  task automatic t_reset;
    chk("R1 code short", 32'(codeS), 0);
    chk("R1 mode short", 32'(modeS), 0);
    chk("R1 valid short", 32'(validS), 1);
    chk("R1 code long", 32'(codeL), 0);
  endtask

  task automatic t_short_write;
    logic [13:0] vals [3] = '{14'h1A5C, 14'h3FFF, 14'h0001};
    foreach (vals[k]) begin
      sendBits(1'b0, {8'h0, 2'b00, vals[k]}, 16, 1'b1, 1'b1);
      chk("R2 short code", 32'(codeS), 32'(vals[k]));
      chk("R2 short mode", 32'(modeS), 0);
      chk("R7 normal to normal keeps valid", 32'(validS), 1);
    end
  endtask

  task automatic t_short_abort;
    sendBits(1'b0, {8'h0, 2'b00, 14'h0777}, 15, 1'b1, 1'b1);
    chk("R4 abort at 15 code", 32'(codeS), 32'h0001);
    chk("R4 abort at 15 mode", 32'(modeS), 0);
    sendBits(1'b0, {8'h0, 2'b11, 14'h2AAA}, 10, 1'b1, 1'b1);
    chk("R4 abort at 10 mode", 32'(modeS), 0);
    sendBits(1'b0, {8'h0, 2'b00, 14'h1234}, 16, 1'b1, 1'b1);
    chk("R4 fresh frame after abort", 32'(codeS), 32'h1234);
  endtask

  task automatic t_ignore_after_commit;
    sendBits(1'b0, {8'h0, 2'b00, 14'h0F0F}, 16, 1'b1, 1'b0);
    waitc(8);
    chk("R2 commit with select still low", 32'(codeS), 32'h0F0F);
    sendBits(1'b0, {8'h0, 2'b11, 14'h3333}, 16, 1'b0, 1'b1);
    chk("R5 extra edges code", 32'(codeS), 32'h0F0F);
    chk("R5 extra edges mode", 32'(modeS), 0);
  endtask

  task automatic t_idle_clocks;
    sendBits(1'b0, {8'h0, 2'b10, 14'h2222}, 16, 1'b0, 1'b0);
    waitc(8);
    chk("R8 clocks with select high code", 32'(codeS), 32'h0F0F);
    chk("R8 clocks with select high mode", 32'(modeS), 0);
  endtask

  task automatic t_power_down;
    logic [1:0] pds [3] = '{2'b01, 2'b10, 2'b11};
    foreach (pds[k]) begin
      sendBits(1'b0, {8'h0, pds[k], 14'h1111}, 16, 1'b1, 1'b1);
      chk("R6 power-down mode", 32'(modeS), 32'(pds[k]));
      chk("R6 power-down keeps code", 32'(codeS), 32'h0F0F);
      chk("R7 power-down drops valid", 32'(validS), 0);
    end
  endtask

  task automatic t_exit_delay;
    int k = 0;
    sendBits(1'b0, {8'h0, 2'b00, 14'h2468}, 16, 1'b1, 1'b1);
    chk("R7 exit code", 32'(codeS), 32'h2468);
    chk("R7 valid low after exit", 32'(validS), 0);
    while (validS !== 1'b1 && k < 2 * EXIT_DLY) begin
      waitc(1); k++;
    end
    // 12 clocks elapsed since last falling edge; rise due EXIT_DLY+3 after it.
    checks++;
    if (k + 12 < EXIT_DLY || k + 12 > EXIT_DLY + 6) begin
      fails++;
      $display("FAIL R7 exit delay actual=%0d expected=%0d", k + 12, EXIT_DLY + 3);
    end
  endtask

  task automatic t_long;
    sendBits(1'b1, {2'b00, 16'hBEEF, 6'h3F}, 24, 1'b1, 1'b1);
    chk("R3 long code", 32'(codeL), 32'hBEEF);
    chk("R3 long mode", 32'(modeL), 0);
    chk("R3 short unit untouched", 32'(codeS), 32'h2468);
    sendBits(1'b1, {6'h0, 2'b00, 16'h1357}, 17, 1'b1, 1'b1);
    chk("R4 long abort at 17", 32'(codeL), 32'hBEEF);
    sendBits(1'b1, {6'h0, 2'b00, 16'hC001}, 18, 1'b1, 1'b1);
    chk("R3 long select up after 18", 32'(codeL), 32'hC001);
    sendBits(1'b1, {2'b10, 16'h5555, 6'h00}, 24, 1'b1, 1'b1);
    chk("R6 long power-down mode", 32'(modeL), 2);
    chk("R6 long keeps code", 32'(codeL), 32'hC001);
  endtask

  initial begin
    waitc(5);
    rstN = 1'b1;
    waitc(2);
    t_reset();
    t_short_write();
    t_short_abort();
    t_ignore_after_commit();
    t_idle_clocks();
    t_power_down();
    t_exit_delay();
    t_long();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule